// File: doc/BRIEF.md
# Per-Line Locality Mode Classifier

This block keeps the locality state of one shared cache line at the directory, for every core in the system. For each core it holds a mode bit, which says whether that core caches the line privately or reaches it through single-word accesses at the shared cache. In remote mode it also holds a count of those word accesses. The coherence engine sends it one access event per cycle, giving the core and whether the access writes. It also sends eviction or invalidation reports from private caches, and each report carries the number of times the private copy was used. For every access the block returns, one cycle later, whether the answer is a whole line or a single word, together with the updated mode of the requesting core.

Demotion compares the reported private use with a programmable base threshold. Promotion back to private mode happens when the remote-access count reaches a promotion threshold. By default that threshold equals the base. In adaptive mode it doubles each time the core is demoted after a capacity eviction, up to a cap, and it returns to the base once the core proves worthy of private caching.

Top module: `locality_classifier`

## Requirements
- R1: After reset every core is in private mode (`modeRemote` all zero) and `respValid` is low.
- R2: `respValid` rises in the cycle after `accValid`, and `respCore` echoes the core. An access by a private-mode core is answered with a line (`respLine`=1), and the core stays private.
- R3: A report from a private-mode core whose utilization is at least the base threshold leaves the core private. A report below the base threshold moves the core to remote mode.
- R4: An access by a remote-mode core increments its count, saturating at the counter maximum. If the new count is below the promotion threshold, the answer is a word (`respLine`=0, `respRemote`=1). If it reaches the threshold, the answer is a line and the core becomes private.
- R5: A write by one core clears the count of every other remote-mode core. The writer's own count still advances.
- R6: A demoted core starts counting from zero, so with threshold T it needs exactly T accesses to get a line back.
- R7: A base threshold of 0 behaves as 1.
- R8: With `cfgAdaptEn`=1, every demotion caused by an eviction report (`rptEvict`=1) doubles that core's promotion threshold. The doubling stops after `MAX_DOUBLINGS` steps, and the threshold is capped at `RAT_MAX`. A demotion caused by an invalidation (`rptEvict`=0) leaves the threshold unchanged.
- R9: A report that keeps a core private returns that core's promotion threshold to the base.
- R10: With `cfgAdaptEn`=0, the promotion threshold equals the base threshold.
- R11: A report from a core already in remote mode changes neither its mode nor its count.
- R12: When an access and a report arrive in the same cycle, the response is based on the mode held before that cycle, and the report sets the resulting mode. When the two name different cores, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgThresh | input | THR_W | Base threshold (0 treated as 1) |
| cfgAdaptEn | input | 1 | Enable adaptive promotion threshold |
| accValid | input | 1 | Access event strobe |
| accCore | input | $clog2(NUM_CORES) | Requesting core |
| accWrite | input | 1 | Access is a write |
| rptValid | input | 1 | Utilization report strobe |
| rptCore | input | $clog2(NUM_CORES) | Reporting core |
| rptUtil | input | UTIL_W | Private use count of the dropped copy |
| rptEvict | input | 1 | 1 = capacity eviction, 0 = invalidation |
| respValid | output | 1 | Decision valid |
| respLine | output | 1 | 1 = send line, 0 = send word |
| respRemote | output | 1 | Updated mode of the requester (1 = remote) |
| respCore | output | $clog2(NUM_CORES) | Core the decision belongs to |
| modeRemote | output | NUM_CORES | Current mode of every core |

## Verification
An access and a report can land in the same cycle, and this is the collision that matters. The bench drives both in one cycle, first for the same core and then for different cores. In the same-core case, a private core's read meets a low-use report: the bench expects a line response, together with `respRemote` and `modeRemote` showing remote mode. In the different-core case, a write by one core coincides with the demotion of a second core while a third is counting in remote mode. The bench then checks that the second core is remote. It also checks that the third core needs the full threshold again, which shows that the write cleared its count and the demotion did not mask that.

// File: rtl/lc_pkg.sv
package lc_pkg;

  // Action taken on the accessing core
  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_LINE    = 2'd1,
    ACC_WORD    = 2'd2,
    ACC_PROMOTE = 2'd3
  } accAct_e;

  // Action taken on the reporting core
  typedef enum logic [1:0] {
    RPT_NONE       = 2'd0,
    RPT_KEEP       = 2'd1,
    RPT_DEMOTE_CAP = 2'd2,
    RPT_DEMOTE_INV = 2'd3
  } rptAct_e;

  typedef struct packed {
    accAct_e accAct;
    rptAct_e rptAct;
    logic    clrOthers;
    logic    respLine;
    logic    respRemote;
  } strobe_t;

endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int UTIL_W        = 4,
  parameter int THR_W         = 4,
  parameter int MAX_DOUBLINGS = 3,
  parameter int RAT_MAX       = 15,
  parameter int LVL_W         = 2
) (
  input  logic [THR_W-1:0]  cfgThresh,
  input  logic              cfgAdaptEn,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              rptValid,
  input  logic              rptEvict,
  input  logic [UTIL_W-1:0] rptUtil,
  input  logic              sameCore,
  input  logic              accMode,
  input  logic [UTIL_W-1:0] accUtil,
  input  logic [LVL_W-1:0]  accLvl,
  input  logic              rptMode,
  output strobe_t           strobe,
  output logic [UTIL_W-1:0] nextUtil
);

  localparam int WIDE_W   = THR_W + MAX_DOUBLINGS;
  localparam int CMP_W    = (WIDE_W > UTIL_W) ? WIDE_W : UTIL_W;
  localparam int UTIL_MAX = (1 << UTIL_W) - 1;

  logic [THR_W-1:0] thrBase;
  logic [CMP_W-1:0] scaledThr;
  logic [CMP_W-1:0] cappedThr;
  logic [CMP_W-1:0] effThr;
  logic             promote;
  logic             rptBelow;

  always_comb begin
    thrBase   = (cfgThresh == '0) ? THR_W'(1) : cfgThresh;
    scaledThr = CMP_W'(thrBase) << accLvl;
    cappedThr = (scaledThr > CMP_W'(RAT_MAX)) ? CMP_W'(RAT_MAX) : scaledThr;
    effThr    = cfgAdaptEn ? cappedThr : CMP_W'(thrBase);
    nextUtil  = (accUtil == UTIL_W'(UTIL_MAX)) ? accUtil : accUtil + UTIL_W'(1);
    promote   = CMP_W'(nextUtil) >= effThr;
    rptBelow  = CMP_W'(rptUtil) < CMP_W'(thrBase);
  end

  always_comb begin
    strobe = '0;
    if (rptValid && !rptMode) begin
      if (!rptBelow)     strobe.rptAct = RPT_KEEP;
      else if (rptEvict) strobe.rptAct = RPT_DEMOTE_CAP;
      else               strobe.rptAct = RPT_DEMOTE_INV;
    end else begin
      strobe.rptAct = RPT_NONE;
    end

    if (!accValid)    strobe.accAct = ACC_NONE;
    else if (!accMode) strobe.accAct = ACC_LINE;
    else if (promote)  strobe.accAct = ACC_PROMOTE;
    else               strobe.accAct = ACC_WORD;

    strobe.clrOthers = accValid && accWrite;
    strobe.respLine  = (strobe.accAct != ACC_WORD);
    if (sameCore && (strobe.rptAct == RPT_DEMOTE_CAP || strobe.rptAct == RPT_DEMOTE_INV))
      strobe.respRemote = 1'b1;
    else
      strobe.respRemote = (strobe.accAct == ACC_WORD);
  end

endmodule

// File: rtl/lc_datapath.sv
module lc_datapath
  import lc_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int UTIL_W        = 4,
  parameter int MAX_DOUBLINGS = 3,
  parameter int LVL_W         = 2,
  parameter int CID_W         = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic                 accValid,
  input  logic [CID_W-1:0]     accCore,
  input  logic [CID_W-1:0]     rptCore,
  input  logic [UTIL_W-1:0]    nextUtil,
  output logic                 accMode,
  output logic [UTIL_W-1:0]    accUtil,
  output logic [LVL_W-1:0]     accLvl,
  output logic                 rptMode,
  output logic [NUM_CORES-1:0] modeRemote,
  output logic                 respValid,
  output logic                 respLine,
  output logic                 respRemote,
  output logic [CID_W-1:0]     respCore
);

  logic [UTIL_W-1:0] utilArr [NUM_CORES];
  logic [LVL_W-1:0]  lvlArr  [NUM_CORES];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic              remoteQ;
    logic [UTIL_W-1:0] utilQ;
    logic [LVL_W-1:0]  lvlQ;
    logic              rptHit;
    logic              accHit;

    assign rptHit = (rptCore == CID_W'(i)) && (strobe.rptAct != RPT_NONE);
    assign accHit = (accCore == CID_W'(i)) && (strobe.accAct != ACC_NONE);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        remoteQ <= 1'b0;
        utilQ   <= '0;
        lvlQ    <= '0;
      end else if (rptHit) begin
        case (strobe.rptAct)
          RPT_KEEP: lvlQ <= '0;
          RPT_DEMOTE_CAP: begin
            remoteQ <= 1'b1;
            utilQ   <= '0;
            if (lvlQ != LVL_W'(MAX_DOUBLINGS)) lvlQ <= lvlQ + LVL_W'(1);
          end
          RPT_DEMOTE_INV: begin
            remoteQ <= 1'b1;
            utilQ   <= '0;
          end
          default: ;
        endcase
      end else if (accHit) begin
        case (strobe.accAct)
          ACC_WORD: utilQ <= nextUtil;
          ACC_PROMOTE: begin
            remoteQ <= 1'b0;
            utilQ   <= '0;
          end
          default: ;
        endcase
      end else if (strobe.clrOthers && remoteQ) begin
        utilQ <= '0;
      end
    end

    assign modeRemote[i] = remoteQ;
    assign utilArr[i]    = utilQ;
    assign lvlArr[i]     = lvlQ;
  end

  assign accMode = modeRemote[accCore];
  assign accUtil = utilArr[accCore];
  assign accLvl  = lvlArr[accCore];
  assign rptMode = modeRemote[rptCore];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respLine   <= 1'b0;
      respRemote <= 1'b0;
      respCore   <= '0;
    end else begin
      respValid <= accValid;
      if (accValid) begin
        respLine   <= strobe.respLine;
        respRemote <= strobe.respRemote;
        respCore   <= accCore;
      end
    end
  end

endmodule

// File: rtl/locality_classifier.sv
module locality_classifier
  import lc_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int UTIL_W        = 4,
  parameter int THR_W         = 4,
  parameter int MAX_DOUBLINGS = 3,
  parameter int RAT_MAX       = 15,
  parameter int CID_W         = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [THR_W-1:0]     cfgThresh,
  input  logic                 cfgAdaptEn,
  input  logic                 accValid,
  input  logic [CID_W-1:0]     accCore,
  input  logic                 accWrite,
  input  logic                 rptValid,
  input  logic [CID_W-1:0]     rptCore,
  input  logic [UTIL_W-1:0]    rptUtil,
  input  logic                 rptEvict,
  output logic                 respValid,
  output logic                 respLine,
  output logic                 respRemote,
  output logic [CID_W-1:0]     respCore,
  output logic [NUM_CORES-1:0] modeRemote
);

  localparam int LVL_W = $clog2(MAX_DOUBLINGS + 1);

  strobe_t           strobe;
  logic [UTIL_W-1:0] nextUtil;
  logic              accMode;
  logic [UTIL_W-1:0] accUtil;
  logic [LVL_W-1:0]  accLvl;
  logic              rptMode;
  logic              sameCore;

  assign sameCore = accValid && rptValid && (accCore == rptCore);

  lc_ctrl #(
    .UTIL_W(UTIL_W), .THR_W(THR_W), .MAX_DOUBLINGS(MAX_DOUBLINGS),
    .RAT_MAX(RAT_MAX), .LVL_W(LVL_W)
  ) u_ctrl (
    .cfgThresh(cfgThresh), .cfgAdaptEn(cfgAdaptEn),
    .accValid(accValid), .accWrite(accWrite),
    .rptValid(rptValid), .rptEvict(rptEvict), .rptUtil(rptUtil),
    .sameCore(sameCore), .accMode(accMode), .accUtil(accUtil),
    .accLvl(accLvl), .rptMode(rptMode),
    .strobe(strobe), .nextUtil(nextUtil)
  );

  lc_datapath #(
    .NUM_CORES(NUM_CORES), .UTIL_W(UTIL_W), .MAX_DOUBLINGS(MAX_DOUBLINGS),
    .LVL_W(LVL_W), .CID_W(CID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .accValid(accValid), .accCore(accCore), .rptCore(rptCore),
    .nextUtil(nextUtil), .accMode(accMode), .accUtil(accUtil),
    .accLvl(accLvl), .rptMode(rptMode), .modeRemote(modeRemote),
    .respValid(respValid), .respLine(respLine),
    .respRemote(respRemote), .respCore(respCore)
  );

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int NUM_CORES = 4,
  parameter int UTIL_W    = 4,
  parameter int CID_W     = $clog2(NUM_CORES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 accValid,
  input logic [CID_W-1:0]     accCore,
  input logic                 rptValid,
  input logic [CID_W-1:0]     rptCore,
  input logic [UTIL_W-1:0]    rptUtil,
  input logic                 respValid,
  input logic                 respLine,
  input logic                 respRemote,
  input logic [CID_W-1:0]     respCore,
  input logic [NUM_CORES-1:0] modeRemote
);

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> respValid);

  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !respValid);

  p_resp_core_r2: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> respCore == $past(accCore));

  p_private_gets_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !modeRemote[accCore] |=> respLine);

  p_word_means_remote_r4: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respLine |-> respRemote);

  p_zero_use_demotes_r3: assert property (@(posedge clk) disable iff (!rstN)
    rptValid && !modeRemote[rptCore] && rptUtil == '0 |=> modeRemote[$past(rptCore)]);

  p_remote_report_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    rptValid && modeRemote[rptCore] && !(accValid && accCore == rptCore)
    |=> modeRemote[$past(rptCore)]);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !accValid && !rptValid |=> $stable(modeRemote));

  p_two_changes_max_r12: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeRemote ^ $past(modeRemote)) <= 2);

endmodule

bind locality_classifier lc_checker #(.NUM_CORES(NUM_CORES), .UTIL_W(UTIL_W)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accCore(accCore),
  .rptValid(rptValid), .rptCore(rptCore), .rptUtil(rptUtil),
  .respValid(respValid), .respLine(respLine), .respRemote(respRemote),
  .respCore(respCore), .modeRemote(modeRemote)
);

// File: tb/locality_classifier_tb.sv
module locality_classifier_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cfgThresh = 4'd2;
  logic       cfgAdaptEn = 1'b0;
  logic       accValid = 1'b0;
  logic [1:0] accCore = '0;
  logic       accWrite = 1'b0;
  logic       rptValid = 1'b0;
  logic [1:0] rptCore = '0;
  logic [3:0] rptUtil = '0;
  logic       rptEvict = 1'b0;
  logic       respValid, respLine, respRemote;
  logic [1:0] respCore;
  logic [3:0] modeRemote;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  locality_classifier u_dut (
    .clk(clk), .rstN(rstN), .cfgThresh(cfgThresh), .cfgAdaptEn(cfgAdaptEn),
    .accValid(accValid), .accCore(accCore), .accWrite(accWrite),
    .rptValid(rptValid), .rptCore(rptCore), .rptUtil(rptUtil), .rptEvict(rptEvict),
    .respValid(respValid), .respLine(respLine), .respRemote(respRemote),
    .respCore(respCore), .modeRemote(modeRemote)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doAcc(input int core, input bit wr, output bit line, output bit rem);
    @(negedge clk);
    accValid = 1'b1; accCore = core[1:0]; accWrite = wr;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    line = respLine; rem = respRemote;
  endtask

  task automatic doRpt(input int core, input int util, input bit evict);
    @(negedge clk);
    rptValid = 1'b1; rptCore = core[1:0]; rptUtil = util[3:0]; rptEvict = evict;
    @(negedge clk);
    rptValid = 1'b0;
  endtask

  task automatic doBoth(input int aCore, input bit wr, input int rCore, input int util,
                        output bit line, output bit rem);
    @(negedge clk);
    accValid = 1'b1; accCore = aCore[1:0]; accWrite = wr;
    rptValid = 1'b1; rptCore = rCore[1:0]; rptUtil = util[3:0]; rptEvict = 1'b0;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; rptValid = 1'b0;
    line = respLine; rem = respRemote;
  endtask

  task automatic countToLine(input int core, output int n);
    bit l, r;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      doAcc(core, 1'b0, l, r);
      n++;
      if (l) break;
    end
  endtask

  task automatic t_reset();
    chk("R1 modes after reset", modeRemote, 0);
    chk("R1 respValid after reset", respValid, 0);
  endtask

  task automatic t_private();
    bit l, r;
    @(negedge clk); accValid = 1'b1; accCore = 2'd0;
    @(negedge clk); accValid = 1'b0;
    chk("R2 respValid", respValid, 1);
    chk("R2 respCore", respCore, 0);
    chk("R2 private line", respLine, 1);
    chk("R2 stays private", respRemote, 0);
    doAcc(3, 1'b1, l, r);
    chk("R2 private write line", l, 1);
    chk("R2 mode vector", modeRemote, 0);
  endtask

  task automatic t_demote_and_promote();
    bit l, r;
    doRpt(0, 2, 1'b0);
    chk("R3 keep at threshold", modeRemote[0], 0);
    doRpt(1, 1, 1'b0);
    chk("R3 demote below threshold", modeRemote[1], 1);
    doAcc(1, 1'b0, l, r);
    chk("R4 remote word", l, 0);
    chk("R4 remote flag", r, 1);
    doAcc(1, 1'b0, l, r);
    chk("R6 line after exactly T", l, 1);
    chk("R4 promoted", modeRemote[1], 0);
  endtask

  task automatic t_write_clear();
    bit l, r;
    doRpt(1, 0, 1'b0);
    doAcc(1, 1'b0, l, r);
    chk("R5 first word", l, 0);
    doAcc(2, 1'b1, l, r);
    chk("R5 writer line", l, 1);
    doAcc(1, 1'b0, l, r);
    chk("R5 count cleared by write", l, 0);
    doAcc(1, 1'b0, l, r);
    chk("R5 line after recount", l, 1);
    doRpt(1, 0, 1'b0);
    doAcc(1, 1'b0, l, r);
    doAcc(1, 1'b1, l, r);
    chk("R5 own write counts", l, 1);
  endtask

  task automatic t_remote_report_ignored();
    int n;
    doRpt(1, 0, 1'b0);
    doRpt(1, 15, 1'b1);
    chk("R11 remote report keeps mode", modeRemote[1], 1);
    countToLine(1, n);
    chk("R11 count untouched", n, 2);
  endtask

  task automatic t_thr_zero();
    int n;
    cfgThresh = 4'd0;
    doRpt(3, 0, 1'b0);
    chk("R7 zero util demotes", modeRemote[3], 1);
    countToLine(3, n);
    chk("R7 threshold 0 acts as 1", n, 1);
    cfgThresh = 4'd2;
  endtask

  task automatic t_adaptive();
    int n;
    cfgAdaptEn = 1'b1;
    doRpt(2, 1, 1'b1); countToLine(2, n);
    chk("R8 doubled once", n, 4);
    doRpt(2, 1, 1'b1); countToLine(2, n);
    chk("R8 doubled twice", n, 8);
    doRpt(2, 1, 1'b1); countToLine(2, n);
    chk("R8 capped", n, 15);
    doRpt(2, 1, 1'b1); countToLine(2, n);
    chk("R8 doubling limit", n, 15);
    doRpt(2, 1, 1'b0); countToLine(2, n);
    chk("R8 invalidation keeps threshold", n, 15);
    doRpt(2, 5, 1'b0);
    chk("R9 keep private", modeRemote[2], 0);
    doRpt(2, 1, 1'b0); countToLine(2, n);
    chk("R9 threshold back to base", n, 2);
    cfgAdaptEn = 1'b0;
    doRpt(0, 1, 1'b1); countToLine(0, n);
    chk("R10 adaptive off uses base", n, 2);
  endtask

  task automatic t_collision();
    bit l, r;
    doBoth(3, 1'b0, 3, 0, l, r);
    chk("R12 same core line from old mode", l, 1);
    chk("R12 same core result remote", r, 1);
    chk("R12 same core mode", modeRemote[3], 1);
    doRpt(0, 0, 1'b0);
    doAcc(0, 1'b0, l, r);
    doBoth(2, 1'b1, 1, 0, l, r);
    chk("R12 writer line", l, 1);
    chk("R12 other core demoted", modeRemote[1], 1);
    doAcc(0, 1'b0, l, r);
    chk("R12 write cleared third core", l, 0);
    doAcc(0, 1'b0, l, r);
    chk("R12 third core promoted", l, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_private();
    t_demote_and_promote();
    t_write_clear();
    t_remote_report_ignored();
    t_thr_zero();
    t_adaptive();
    t_collision();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule